// File: doc/BRIEF.md
# Wraparound Bit-Range Mask Generator

This block turns two bit positions, a first position and a last position, into a mask word with a contiguous run of ones. Positions count from the most significant end: position 0 is the top bit of the word and the highest position is bit 0 of the port. If the first position is not past the last one, the run covers the positions between them, both ends included. If the first position is past the last one, the run wraps around. It covers everything from the first position down to the bottom of the word, and everything from position 0 up to the last position. Only the stretch strictly between the two ends stays clear.

A rotate-and-mask datapath uses the mask to pick a field. A parameter adds an output register with one cycle of latency and a valid flag. With the register left out, the mask follows the inputs in the same cycle.

Top module: `wrap_mask_gen`

## Requirements
- R1: Position p maps to port bit `mask_out[W-1-p]`, where W = 2^POS_W (64 by default). Position 0 drives the most significant port bit, and both named end positions are always set.
- R2: When `first_pos` <= `last_pos`, exactly the positions from `first_pos` to `last_pos` inclusive are one. That is `last_pos - first_pos + 1` ones.
- R3: When `first_pos` equals `last_pos`, exactly one bit is set, at that position.
- R4: When `first_pos` > `last_pos`, these positions are one: `first_pos` to W-1, and 0 to `last_pos`. Every position strictly between `last_pos` and `first_pos` is zero. That is `W - first_pos + last_pos + 1` ones.
- R5: When `first_pos` equals `last_pos + 1`, every bit of the mask is one.
- R6: With `REG_OUT` = 0, the mask is a purely combinational function of the positions in the same cycle. `out_valid` equals `in_valid` while `rst_n` is high and is 0 while `rst_n` is low.
- R7: With `REG_OUT` = 1, the mask for positions presented with `in_valid` high appears on `mask_out` after the next rising clock edge. `out_valid` is `in_valid` delayed by one cycle.
- R8: With `REG_OUT` = 1, a cycle with `in_valid` low leaves `mask_out` unchanged and drives `out_valid` to 0 after the edge.
- R9: With `REG_OUT` = 1, a low `rst_n` clears `mask_out` to zero and `out_valid` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Positions on the inputs are meaningful this cycle |
| first_pos | input | POS_W | Position where the run of ones begins (0 = MSB) |
| last_pos | input | POS_W | Position where the run of ones ends (0 = MSB) |
| mask_out | output | 2^POS_W | Generated mask, position p on bit W-1-p |
| out_valid | output | 1 | `mask_out` holds a mask for valid positions |

## Verification
A wrong comparison between the two positions would show up as a wrapped mask where a plain run belongs, or the reverse. The number of set bits would then be wrong for that pair, visible on `mask_out` in the same cycle, or one edge later with the register. A shift amount that is off by one would move an end bit or drop it. The all-ones case at `first_pos = last_pos + 1` and the one-hot case on the diagonal expose this at once. Every pair of positions is compared against an independent position-by-position model. So a fault in any single position shows up on the first pair that touches it. A register that loads when it should hold would change `mask_out` one edge after a cycle with `in_valid` low.

// File: rtl/wrap_mask_gen.sv
module wrap_mask_gen #(
  parameter int POS_W   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [POS_W-1:0]        first_pos,
  input  logic [POS_W-1:0]        last_pos,
  output logic [(1<<POS_W)-1:0]   mask_out,
  output logic                    out_valid
);
  localparam int W = 1 << POS_W;

  logic [W-1:0]   all_ones;
  logic [POS_W:0] stop_next;
  logic [W-1:0]   from_first;
  logic [W-1:0]   upto_last;
  logic           wraps;
  logic [W-1:0]   mask_c;

  assign all_ones   = '1;
  assign stop_next  = {1'b0, last_pos} + 1'b1;
  assign from_first = all_ones >> first_pos;
  assign upto_last  = ~(all_ones >> stop_next);
  assign wraps      = first_pos > last_pos;
  assign mask_c     = wraps ? (from_first | upto_last) : (from_first & upto_last);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_out  <= '0;
          out_valid <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) mask_out <= mask_c;
        end
      end
    end else begin : g_comb
      assign mask_out  = mask_c;
      assign out_valid = in_valid & rst_n;
    end
  endgenerate
endmodule

module wrap_mask_gen_chk #(
  parameter int POS_W   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [POS_W-1:0]      first_pos,
  input logic [POS_W-1:0]      last_pos,
  input logic [(1<<POS_W)-1:0] mask_out,
  input logic                  out_valid
);
  localparam int W = 1 << POS_W;

  logic             v;
  logic [POS_W-1:0] s, e;
  int               exp_cnt;

  generate
    if (REG_OUT) begin : g_r
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v <= 1'b0; s <= '0; e <= '0;
        end else begin
          v <= in_valid;
          if (in_valid) begin s <= first_pos; e <= last_pos; end
        end
      end
      AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R7
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
      AST_HOLD_MASK: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(mask_out)); // R8
    end else begin : g_c
      assign v = in_valid;
      assign s = first_pos;
      assign e = last_pos;
      AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rst_n) out_valid == in_valid); // R6
    end
  endgenerate

  always_comb exp_cnt = (s <= e) ? (int'(e) - int'(s) + 1) : (W - int'(s) + int'(e) + 1);

  AST_END_BITS: assert property (@(posedge clk) disable iff (!rst_n) v |-> (mask_out[W-1-int'(s)] && mask_out[W-1-int'(e)])); // R1
  AST_FIELD_SIZE: assert property (@(posedge clk) disable iff (!rst_n) (v && s <= e) |-> ($countones(mask_out) == exp_cnt)); // R2
  AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n) (v && s == e) |-> ($countones(mask_out) == 1)); // R3
  AST_WRAP_SIZE: assert property (@(posedge clk) disable iff (!rst_n) (v && s > e) |-> ($countones(mask_out) == exp_cnt)); // R4
  AST_WRAP_GAP: assert property (@(posedge clk) disable iff (!rst_n) (v && int'(s) > int'(e) + 1) |-> !mask_out[W-2-int'(e)]); // R4
  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (v && s > e && int'(s) == int'(e) + 1) |-> (&mask_out)); // R5
endmodule

bind wrap_mask_gen wrap_mask_gen_chk #(.POS_W(POS_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_pos(first_pos),
  .last_pos(last_pos), .mask_out(mask_out), .out_valid(out_valid)
);

// File: tb/test_wrap_mask_gen.sv
module test_wrap_mask_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  first_pos = '0, last_pos = '0;
  logic [63:0] mask_r, mask_c;
  logic        valid_r, valid_c;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  wrap_mask_gen #(.POS_W(6), .REG_OUT(1'b1)) i_wrap_mask_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_pos(first_pos),
    .last_pos(last_pos), .mask_out(mask_r), .out_valid(valid_r));

  wrap_mask_gen #(.POS_W(6), .REG_OUT(1'b0)) i_wrap_mask_gen_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_pos(first_pos),
    .last_pos(last_pos), .mask_out(mask_c), .out_valid(valid_c));

  typedef struct packed { logic [5:0] s; logic [5:0] e; logic [63:0] m; } vec_t;
  // Position 0 is port bit 63 (R1).
  localparam vec_t VECS [12] = '{
    '{6'd0,  6'd63, 64'hFFFF_FFFF_FFFF_FFFF},
    '{6'd0,  6'd0,  64'h8000_0000_0000_0000},
    '{6'd63, 6'd63, 64'h0000_0000_0000_0001},
    '{6'd0,  6'd7,  64'hFF00_0000_0000_0000},
    '{6'd56, 6'd63, 64'h0000_0000_0000_00FF},
    '{6'd4,  6'd11, 64'h0FF0_0000_0000_0000},
    '{6'd16, 6'd47, 64'h0000_FFFF_FFFF_0000},
    '{6'd60, 6'd3,  64'hF000_0000_0000_000F},
    '{6'd1,  6'd0,  64'hFFFF_FFFF_FFFF_FFFF},
    '{6'd63, 6'd0,  64'h8000_0000_0000_0001},
    '{6'd32, 6'd31, 64'hFFFF_FFFF_FFFF_FFFF},
    '{6'd40, 6'd23, 64'hFFFF_FF00_00FF_FFFF}
  };

  function automatic string tag_of(logic [5:0] s, logic [5:0] e);
    if (s == e) return "R3";
    if (s > e && int'(s) == int'(e) + 1) return "R5";
    if (s > e) return "R4";
    return "R2";
  endfunction

  function automatic logic [63:0] model(logic [5:0] s, logic [5:0] e);
    logic [63:0] m = '0;
    for (int p = 0; p < 64; p++)
      if ((s <= e) ? (p >= s && p <= e) : (p >= s || p <= e)) m[63-p] = 1'b1;
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] s, logic [5:0] e, logic [63:0] exp, string req);
    @(negedge clk);
    first_pos = s; last_pos = e; in_valid = 1'b1;
    #1;
    chk({req, " comb R6"}, mask_c, exp);
    @(posedge clk); #1;
    chk({req, " reg R7"}, mask_r, exp);
    chk("R7 valid", {63'd0, valid_r}, 64'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; first_pos = 6'd3; last_pos = 6'd9;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 reset mask", mask_r, 64'd0);
    chk("R9 reset valid", {63'd0, valid_r}, 64'd0);
    chk("R6 valid gated in reset", {63'd0, valid_c}, 64'd0);
    @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;

    foreach (VECS[i]) apply(VECS[i].s, VECS[i].e, VECS[i].m, tag_of(VECS[i].s, VECS[i].e));

    apply(6'd0, 6'd0, 64'h8000_0000_0000_0000, "R3");
    chk("R1 position 0 is MSB", {63'd0, mask_r[63]}, 64'd1);

    // Hold: in_valid low with new positions (R8)
    @(negedge clk); first_pos = 6'd10; last_pos = 6'd20; in_valid = 1'b0;
    #1; chk("R6 valid low", {63'd0, valid_c}, 64'd0);
    @(posedge clk); #1;
    chk("R8 hold mask", mask_r, 64'h8000_0000_0000_0000);
    chk("R8 valid low", {63'd0, valid_r}, 64'd0);

    for (int s = 0; s < 64; s++)
      for (int e = 0; e < 64; e++)
        apply(6'(s), 6'(e), model(6'(s), 6'(e)), tag_of(6'(s), 6'(e)));

    @(negedge clk); rst_n = 1'b0; #1;
    chk("R9 async clear mask", mask_r, 64'd0);
    chk("R9 async clear valid", {63'd0, valid_r}, 64'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule